// File: doc/BRIEF.md
# Watchdog Down-Counter with Timeout Pulse

This block is a programmable down-counter for supervising software and bus activity. It runs on the fast system clock. A separate enable input, active for one fast cycle per peripheral clock period, lets the count move down by one. When the count expires, the counter reloads itself from a stored reload value and does not wrap. At the same moment a timeout output goes high for a fixed number of fast cycles, so a reset controller or an interrupt controller can use it directly.

A small write port holds three things: the reload value, an operating mode and a service register. There are three modes:
- **Watchdog mode.** Only a two-word key handshake on the service register restarts the count.
- **Bus-monitor mode.** The count restarts at the start of every bus cycle and freezes when the bus reports ready. A timeout therefore only occurs on a cycle that never completes.
- **General-timer mode.** The counter just reloads and keeps running, which gives a periodic pulse.

Top module: `wdog_timer`

## Requirements
- R1: On reset, `timeout_o` is low, the mode is watchdog, and both the counter and the reload register hold the parameter `RST_RELOAD`. The counter runs from release of reset.
- R2: While the counter runs, each clock edge with `tick_en` high reduces the count by one. The N-th tick after a load of value N (a value of 0 behaves as 1) is the expiry edge, and `timeout_o` is high right after that edge. Without a tick or a load the count is held.
- R3: After an expiry, `timeout_o` stays high for exactly `PULSE_LEN` (16) clock cycles. A further expiry inside that window starts the 16 cycles again.
- R4: At expiry the counter takes the current reload value. In watchdog and general-timer modes it keeps running, so with no other action expiries repeat every reload-value ticks.
- R5: A write with `wr_sel`=0 stores `wr_data` as the reload value. It does not disturb the count in progress, and it takes effect at the next load.
- R6: A write with `wr_sel`=1 sets the mode from `wr_data[1:0]` and loads the counter from the reload value. The encodings are 0 watchdog, 1 bus monitor, 2 general timer and 3 watchdog.
- R7: In watchdog mode, service writes (`wr_sel`=2) are compared on `wr_data[15:0]`:
  - 0xAAAA arms the key check.
  - 0x5555 on the next service write while armed loads the counter.
  - Any other service value disarms.
  - Writes to the other selectors leave the armed state alone, and the upper data bits are ignored.
- R8: In bus-monitor and general-timer modes, service writes do not change the count and leave the key check disarmed.
- R9: In bus-monitor mode:
  - After a mode write the counter is stopped.
  - `bus_start` loads the counter and runs it.
  - `bus_rdy` stops it; if both arrive in one cycle, the counter is loaded and stopped.
  - After an expiry the counter stays stopped until the next `bus_start`, so a hung cycle gives a single pulse.
- R10: A load (mode write, valid key or bus start) on the same edge as an expiry takes priority. That expiry gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable, one fast cycle per peripheral clock period |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload value, 1 mode, 2 service key, 3 unused |
| wr_data | input | CNT_W | Write data |
| bus_start | input | 1 | Start of a bus cycle (bus-monitor mode) |
| bus_rdy | input | 1 | Bus cycle completed (bus-monitor mode) |
| timeout_o | output | 1 | Timeout pulse, PULSE_LEN fast cycles long |

## Verification
The assertions assume that reset is asserted from time zero and that every input is a known value at each sampling edge after reset. They also assume that ticks, writes and bus events are single-cycle levels that the counter samples on the rising edge. The stimulus changes every input only on the falling clock edge and holds it for one full cycle. In the sweeps the reload value and the tick spacing are chosen so that both overlapping pulses (reload times spacing of 16 or less) and separated pulses occur. Key, bus and reload events are placed on exact cycle numbers, including the expiry edge itself, so that the priority and stop rules are reached.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        WM_WATCH  = 2'd0,
        WM_BUSMON = 2'd1,
        WM_TIMER  = 2'd2,
        WM_WATCH2 = 2'd3
    } wd_mode_e;

    typedef enum logic [1:0] {
        RS_RELOAD  = 2'd0,
        RS_MODE    = 2'd1,
        RS_SERVICE = 2'd2,
        RS_SPARE   = 2'd3
    } wd_sel_e;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq #(
    parameter int               KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY_ARM  = 'hAAAA,
    parameter logic [KEY_W-1:0] KEY_FIRE = 'h5555
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc_wr_i,
    input  logic             watch_i,
    input  logic [KEY_W-1:0] key_i,
    output logic             load_o
);

    typedef struct packed {
        logic armed;
    } ks_t;

    ks_t ks_d, ks_q;

    always_comb begin
        ks_d   = ks_q;
        load_o = 1'b0;
        if (svc_wr_i) begin
            load_o     = watch_i && ks_q.armed && (key_i == KEY_FIRE);
            ks_d.armed = watch_i && (key_i == KEY_ARM);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= '{armed: 1'b0};
        end else begin
            ks_q <= ks_d;
        end
    end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int               CNT_W      = 32,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rl_wr_i,
    input  logic [CNT_W-1:0] rl_data_i,
    input  logic             load_i,
    input  logic             load_run_i,
    input  logic             stop_i,
    input  logic             keep_run_i,
    output logic             expire_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             running_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             running;
    } cs_t;

    cs_t cs_d, cs_q;

    always_comb begin
        cs_d     = cs_q;
        expire_o = 1'b0;
        if (rl_wr_i) begin
            cs_d.reload = rl_data_i;
        end
        if (load_i) begin
            // any explicit load wins over the tick of this edge
            cs_d.cnt     = cs_q.reload;
            cs_d.running = load_run_i;
        end else begin
            if (cs_q.running && tick_i) begin
                if (cs_q.cnt <= ONE) begin
                    expire_o     = 1'b1;
                    cs_d.cnt     = cs_q.reload;
                    cs_d.running = keep_run_i;
                end else begin
                    cs_d.cnt = cs_q.cnt - ONE;
                end
            end
            if (stop_i) begin
                cs_d.running = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '{cnt: RST_RELOAD, reload: RST_RELOAD, running: 1'b1};
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count_o   = cs_q.cnt;
    assign reload_o  = cs_q.reload;
    assign running_o = cs_q.running;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int            PW  = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

    typedef struct packed {
        logic [PW-1:0] left;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (trig_i) begin
            ps_d.left = LEN;
        end else if (ps_q.left != '0) begin
            ps_d.left = ps_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '{left: '0};
        end else begin
            ps_q <= ps_d;
        end
    end

    assign pulse_o = (ps_q.left != '0);

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               PULSE_LEN  = 16,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] KEY_ARM    = 'hAAAA,
    parameter logic [KEY_W-1:0] KEY_FIRE   = 'h5555,
    parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             bus_start,
    input  logic             bus_rdy,
    output logic             timeout_o
);

    typedef struct packed {
        wd_mode_e mode;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             mode_wr_w, svc_wr_w, rl_wr_w;
    logic             is_bus_w, is_watch_w;
    logic             svc_load_w, load_w, load_run_w, stop_w, keep_w;
    logic             expire_w, running_w;
    logic [CNT_W-1:0] cnt_w, reload_w;

    // decode of the write port and mode-dependent control
    always_comb begin
        mode_wr_w  = wr_en && (wr_sel == RS_MODE);
        svc_wr_w   = wr_en && (wr_sel == RS_SERVICE);
        rl_wr_w    = wr_en && (wr_sel == RS_RELOAD);
        is_bus_w   = (ctl_q.mode == WM_BUSMON);
        is_watch_w = (ctl_q.mode == WM_WATCH) || (ctl_q.mode == WM_WATCH2);

        load_w = mode_wr_w || svc_load_w || (is_bus_w && bus_start);
        if (mode_wr_w) begin
            load_run_w = (wr_data[1:0] != WM_BUSMON);
        end else if (svc_load_w) begin
            load_run_w = 1'b1;
        end else begin
            load_run_w = !bus_rdy;
        end
        stop_w = is_bus_w && bus_rdy;
        keep_w = !is_bus_w;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (mode_wr_w) begin
            ctl_d.mode = wd_mode_e'(wr_data[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{mode: WM_WATCH};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    wdog_keyseq #(
        .KEY_W   (KEY_W),
        .KEY_ARM (KEY_ARM),
        .KEY_FIRE(KEY_FIRE)
    ) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .svc_wr_i(svc_wr_w),
        .watch_i (is_watch_w),
        .key_i   (wr_data[KEY_W-1:0]),
        .load_o  (svc_load_w)
    );

    wdog_count #(
        .CNT_W     (CNT_W),
        .RST_RELOAD(RST_RELOAD)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_en),
        .rl_wr_i   (rl_wr_w),
        .rl_data_i (wr_data),
        .load_i    (load_w),
        .load_run_i(load_run_w),
        .stop_i    (stop_w),
        .keep_run_i(keep_w),
        .expire_o  (expire_w),
        .count_o   (cnt_w),
        .reload_o  (reload_w),
        .running_o (running_w)
    );

    wdog_pulse #(
        .PULSE_LEN(PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (expire_w),
        .pulse_o(timeout_o)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             bus_rdy,
    input logic             timeout_o,
    input logic             is_bus,
    input logic             load,
    input logic             expire,
    input logic             running,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload
);

    localparam int            RW   = $clog2(PULSE_LEN + 2);
    localparam logic [RW-1:0] RMAX = '1;
    localparam logic [RW-1:0] PLEN = RW'(PULSE_LEN);

    logic [RW-1:0] run_q;

    // length of the current high stretch, restarted at each expiry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (expire) begin
            run_q <= '0;
        end else if (!timeout_o) begin
            run_q <= '0;
        end else if (run_q != RMAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !timeout_o);

    assert_expire_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> timeout_o);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(count));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_o) |-> (run_q == PLEN));

    assert_pulse_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(expire));

    assert_reload_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload)));

    assert_bus_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bus && bus_rdy && !load) |=> !running);

endmodule

bind wdog_timer wdog_timer_chk #(
    .CNT_W    (CNT_W),
    .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_rdy  (bus_rdy),
    .timeout_o(timeout_o),
    .is_bus   (is_bus_w),
    .load     (load_w),
    .expire   (expire_w),
    .running  (running_w),
    .count    (cnt_w),
    .reload   (reload_w)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        bus_start;
    logic        bus_rdy;
    logic        timeout_o;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    localparam logic [31:0] KA = 32'h0000AAAA;
    localparam logic [31:0] KB = 32'h00005555;

    always #5 clk = ~clk;

    wdog_timer #(.RST_RELOAD(32'd40)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .bus_start(bus_start),
        .bus_rdy  (bus_rdy),
        .timeout_o(timeout_o)
    );

    // expected level after edge i: high in the 16 cycles from each expiry
    function automatic bit exp_hi(input int i, input int e1, input int per);
        if (e1 <= 0 || i < e1) return 1'b0;
        if (per == 0) return (i - e1) < 16;
        return ((i - e1) % per) < 16;
    endfunction

    task automatic step(input logic tk, input logic we, input logic [1:0] sel,
                        input logic [31:0] d, input logic bs, input logic br);
        tick_en = tk; wr_en = we; wr_sel = sel; wr_data = d;
        bus_start = bs; bus_rdy = br;
        @(negedge clk);
    endtask

    task automatic check(input logic expv, input string tag, input int i);
        n_chk++;
        if (timeout_o !== expv) begin
            n_err++;
            $display("FAIL %s cycle %0d timeout_o=%b expected %b", tag, i, timeout_o, expv);
        end
    endtask

    task automatic prep(input int rl, input int mode);
        repeat (18) step(1'b0, 1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 2'd0, 32'(rl), 1'b0, 1'b0);
        step(1'b0, 1'b1, 2'd1, 32'(mode), 1'b0, 1'b0);
    endtask

    // reload 30, tick every cycle, up to three writes at chosen cycles
    task automatic run_seq(input int mode,
                           input int c1, input logic [1:0] s1, input logic [31:0] d1,
                           input int c2, input logic [1:0] s2, input logic [31:0] d2,
                           input int c3, input logic [1:0] s3, input logic [31:0] d3,
                           input int e1, input int per, input string tag);
        prep(30, mode);
        for (int i = 1; i <= 110; i++) begin
            if (i == c1)      step(1'b1, 1'b1, s1, d1, 1'b0, 1'b0);
            else if (i == c2) step(1'b1, 1'b1, s2, d2, 1'b0, 1'b0);
            else if (i == c3) step(1'b1, 1'b1, s3, d3, 1'b0, 1'b0);
            else              step(1'b1, 1'b0, 2'd3, 32'd0, 1'b0, 1'b0);
            check(exp_hi(i, e1, per), tag, i);
        end
    endtask

    task automatic run_bus(input int s1, input int r1, input int s2,
                           input int e1, input string tag);
        prep(20, 1);
        for (int i = 1; i <= 70; i++) begin
            step(1'b1, 1'b0, 2'd3, 32'd0, (i == s1) || (i == s2), (i == r1));
            check(exp_hi(i, e1, 0), tag, i);
        end
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; wr_sel = 2'd3;
        wr_data = 32'd0; bus_start = 1'b0; bus_rdy = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, "R1 reset", 0);
        rst_n = 1'b1;
        // R1: reset value 40 counts down in watchdog mode from release
        for (int i = 1; i <= 100; i++) begin
            step(1'b1, 1'b0, 2'd3, 32'd0, 1'b0, 1'b0);
            check(exp_hi(i, 40, 40), "R1 R4", i);
        end

        // R2 R3 R4: general-timer sweep over reload value and tick spacing
        for (int k = 1; k <= 3; k++) begin
            for (int r = 0; r <= 24; r++) begin
                int t;
                t = ((r == 0) ? 1 : r) * k;
                prep(r, 2);
                for (int i = 1; i <= 2 * t + 20; i++) begin
                    step((i % k) == 0, 1'b0, 2'd3, 32'd0, 1'b0, 1'b0);
                    check(exp_hi(i, t, t), "R2 R3 R4", i);
                end
            end
        end

        // R7: key handshake in watchdog mode
        run_seq(0, 10, 2'd2, KA, 11, 2'd2, KB, 0, 2'd0, 0, 41, 30, "R7 pair");
        run_seq(0, 10, 2'd2, 32'h1234AAAA, 11, 2'd2, 32'hFFFF5555, 0, 2'd0, 0, 41, 30, "R7 upper bits");
        run_seq(0, 10, 2'd2, KA, 11, 2'd2, 32'h1234, 12, 2'd2, KB, 30, 30, "R7 broken");
        run_seq(0, 10, 2'd2, KB, 0, 2'd0, 0, 0, 2'd0, 0, 30, 30, "R7 lone second");
        run_seq(0, 10, 2'd2, KA, 11, 2'd2, KA, 12, 2'd2, KB, 42, 30, "R7 rearm");
        run_seq(0, 10, 2'd2, KA, 15, 2'd2, KB, 0, 2'd0, 0, 45, 30, "R7 gap");
        run_seq(0, 10, 2'd2, KA, 11, 2'd0, 32'd30, 12, 2'd2, KB, 42, 30, "R7 other sel");
        // R6: mode encoding 3 acts as watchdog; mode write restarts count
        run_seq(3, 10, 2'd2, KA, 11, 2'd2, KB, 0, 2'd0, 0, 41, 30, "R6 code3");
        run_seq(2, 20, 2'd1, 32'd2, 0, 2'd0, 0, 0, 2'd0, 0, 50, 30, "R6 restart");
        // R8: keys ignored outside watchdog mode
        run_seq(2, 10, 2'd2, KA, 11, 2'd2, KB, 0, 2'd0, 0, 30, 30, "R8 timer");
        // R5: reload write does not disturb running count
        run_seq(2, 5, 2'd0, 32'd50, 0, 2'd0, 0, 0, 2'd0, 0, 30, 50, "R5");
        // R10: key load on the expiry edge suppresses the pulse
        run_seq(0, 29, 2'd2, KA, 30, 2'd2, KB, 0, 2'd0, 0, 60, 30, "R10");

        // R9: bus monitor
        run_bus(0, 0, 0, 0, "R9 idle");
        run_bus(1, 0, 0, 21, "R9 hung");
        run_bus(1, 6, 0, 0, "R9 ready");
        run_bus(1, 1, 0, 0, "R9 same cycle");
        run_bus(1, 0, 15, 35, "R9 restart");
        // R8: service keys ignored in bus-monitor mode
        prep(20, 1);
        for (int i = 1; i <= 40; i++) begin
            if (i == 3)      step(1'b1, 1'b1, 2'd2, KA, 1'b0, 1'b0);
            else if (i == 4) step(1'b1, 1'b1, 2'd2, KB, 1'b0, 1'b0);
            else             step(1'b1, 1'b0, 2'd3, 32'd0, 1'b0, 1'b0);
            check(1'b0, "R8 busmon", i);
        end

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL bench watchdog expired (R1..R10 incomplete)");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule